// File: doc/BRIEF.md
# Coefficient Table Access Port

This block stores two small lookup memories that a host fills and inspects over a narrow register bus. One is a gamma table of 256 bytes. The other is a filter coefficient table of 32 bytes. The host never addresses an entry directly. It first writes an index register and then streams through a data register. Each data access, read or write, reaches the entry the index points to and then advances the index by one.

The two indices handle the end of their table differently. The gamma index rolls over from 255 to 0. The filter index stops one step past the last entry. In that parked state the table ignores data writes and returns zero on data reads, until the host loads a new index.

Two configuration bytes sit beside the tables, one for each table, and each keeps only its legal bits. A separate pixel-side port reads the gamma table combinationally and leaves the host index untouched. The block does not apply gamma correction or filtering to pixels.

Top module: `coef_table_port`

## Requirements
- R1: After reset both configuration bytes and both indices read 0, every gamma entry is 0, and `rd_valid` is low.
- R2: The gamma configuration register (address 0) keeps only the bits in mask 0x87. The filter configuration register (address 3) keeps only the bits in mask 0xBF. A configuration register changes only when it is written.
- R3: A write to the gamma index register (address 1) loads all 8 bits. A read of it returns the current index.
- R4: A write to the gamma data register (address 2) stores the byte at the current gamma index and then increments the index modulo 256, so 255 is followed by 0.
- R5: A read of the gamma data register returns the entry at the current gamma index and then increments the index modulo 256.
- R6: A write to the filter index register (address 4) stores only bits [4:0] of the write data. A read of it returns the index, which can be 0 to 32.
- R7: A filter data access (address 5) while the filter index is below 32 writes or reads that entry and then increments the index.
- R8: While the filter index equals 32, filter data writes are dropped, filter data reads return 0, and the index stays at 32.
- R9: Data accesses on consecutive cycles each use the index as already advanced by the access before them.
- R10: Read data appears on `rd_data` with `rd_valid` high in the cycle after the read is presented. `rd_valid` is low in every other cycle.
- R11: `pix_gamma` equals the gamma entry at `pix_idx` in the same cycle, and changing `pix_idx` never moves the host gamma index.
- R12: Addresses 6 and 7 ignore writes and read as 0. When `bus_wr` and `bus_rd` are both high, the write is performed and the read is ignored, so no `rd_valid` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Host write data |
| rd_valid | output | 1 | Read data valid, one cycle after the read |
| rd_data | output | 8 | Read data |
| pix_idx | input | 8 | Pixel-side gamma lookup index |
| pix_gamma | output | 8 | Gamma entry at `pix_idx` |

## Verification
Host read data is registered, so each read result is due exactly one cycle after the read strobe. Index and table updates take effect at that same edge and are therefore seen by an access on the very next cycle. The bench pushes the expected value of every read into a queue as it drives the read. A monitor sampling on the falling edge pops one item for each `rd_valid` it sees, so a late, early or missing result shows up as a mismatch or as a leftover queue entry. The pixel port has no register, so it is checked a fraction of a cycle after `pix_idx` changes. Each pixel check is followed by a host read of the gamma index to confirm the index did not move.

// File: rtl/coef_table_port.sv
module coef_table_port #(
  parameter int DW        = 8,
  parameter int GAM_DEPTH = 256,
  parameter int FLT_DEPTH = 32,
  parameter int AW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic [$clog2(GAM_DEPTH)-1:0] pix_idx,
  output logic [DW-1:0] pix_gamma
);
  localparam int GIW = $clog2(GAM_DEPTH);
  localparam int FIW = $clog2(FLT_DEPTH) + 1;
  localparam logic [DW-1:0] GMASK = DW'(8'h87);
  localparam logic [DW-1:0] FMASK = DW'(8'hBF);
  localparam logic [AW-1:0] A_GCTL = AW'(0);
  localparam logic [AW-1:0] A_GIDX = AW'(1);
  localparam logic [AW-1:0] A_GDAT = AW'(2);
  localparam logic [AW-1:0] A_FCTL = AW'(3);
  localparam logic [AW-1:0] A_FIDX = AW'(4);
  localparam logic [AW-1:0] A_FDAT = AW'(5);

  logic [DW-1:0]  gam_tab [GAM_DEPTH];
  logic [DW-1:0]  flt_tab [FLT_DEPTH];
  logic [GIW-1:0] gam_idx;
  logic [FIW-1:0] flt_idx;
  logic [DW-1:0]  gam_ctl, flt_ctl;
  logic [DW-1:0]  rmux;
  logic           rd, f_ok;

  assign rd        = bus_rd & ~bus_wr;
  assign f_ok      = flt_idx < FIW'(FLT_DEPTH);
  assign pix_gamma = gam_tab[pix_idx];

  always_comb begin
    case (bus_addr)
      A_GCTL:  rmux = gam_ctl;
      A_GIDX:  rmux = DW'(gam_idx);
      A_GDAT:  rmux = gam_tab[gam_idx];
      A_FCTL:  rmux = flt_ctl;
      A_FIDX:  rmux = DW'(flt_idx);
      A_FDAT:  rmux = f_ok ? flt_tab[flt_idx[FIW-2:0]] : '0;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gam_idx  <= '0;
      flt_idx  <= '0;
      gam_ctl  <= '0;
      flt_ctl  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      for (int i = 0; i < GAM_DEPTH; i++) gam_tab[i] <= '0;
      for (int i = 0; i < FLT_DEPTH; i++) flt_tab[i] <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) rd_data <= rmux;
      if (bus_wr) begin
        case (bus_addr)
          A_GCTL: gam_ctl <= bus_wdata & GMASK;
          A_GIDX: gam_idx <= bus_wdata[GIW-1:0];
          A_GDAT: begin
            gam_tab[gam_idx] <= bus_wdata;
            gam_idx <= gam_idx + 1'b1;
          end
          A_FCTL: flt_ctl <= bus_wdata & FMASK;
          A_FIDX: flt_idx <= {1'b0, bus_wdata[FIW-2:0]};
          A_FDAT: if (f_ok) begin
            flt_tab[flt_idx[FIW-2:0]] <= bus_wdata;
            flt_idx <= flt_idx + 1'b1;
          end
          default: ;
        endcase
      end else if (rd) begin
        if (bus_addr == A_GDAT) gam_idx <= gam_idx + 1'b1;
        if (bus_addr == A_FDAT && f_ok) flt_idx <= flt_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/coef_table_port_chk.sv
module coef_table_port_chk #(
  parameter int AW        = 3,
  parameter int DW        = 8,
  parameter int GIW       = 8,
  parameter int FIW       = 6,
  parameter int FLT_DEPTH = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic           bus_rd,
  input logic [AW-1:0]  bus_addr,
  input logic           rd_valid,
  input logic [DW-1:0]  rd_data,
  input logic [GIW-1:0] gidx,
  input logic [FIW-1:0] fidx,
  input logic [DW-1:0]  gctl
);
  p_rdv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr) |=> rd_valid);
  p_rdv_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && !bus_wr) |=> !rd_valid);
  p_gidx_wr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(2)) |=> gidx == GIW'($past(gidx) + 1'b1));
  p_gidx_rd_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == AW'(2)) |=> gidx == GIW'($past(gidx) + 1'b1));
  p_fidx_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fidx <= FIW'(FLT_DEPTH));
  p_fidx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && bus_addr == AW'(5) && fidx == FIW'(FLT_DEPTH)) |=> fidx == FIW'(FLT_DEPTH));
  p_fzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == AW'(5) && fidx == FIW'(FLT_DEPTH)) |=> rd_data == '0);
  p_gidx_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr || bus_rd) |=> $stable(gidx));
  p_gctl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == AW'(0)) |=> $stable(gctl));
endmodule

bind coef_table_port coef_table_port_chk #(
  .AW(AW), .DW(DW), .GIW(GIW), .FIW(FIW), .FLT_DEPTH(FLT_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .rd_valid(rd_valid), .rd_data(rd_data),
  .gidx(gam_idx), .fidx(flt_idx), .gctl(gam_ctl)
);

// File: tb/tb_coef_table_port.sv
module tb_coef_table_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic [7:0] pix_idx = '0;
  logic [7:0] pix_gamma;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  logic [7:0] gm [256];
  logic [7:0] fm [32];
  int mgi = 0, mfi = 0;
  logic [7:0] mgc = '0, mfc = '0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  coef_table_port dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .pix_idx(pix_idx), .pix_gamma(pix_gamma)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R10 unexpected rd_valid", 8'h01, 8'h00);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d;
    case (a)
      0: mgc = d & 8'h87;
      1: mgi = d;
      2: begin gm[mgi] = d; mgi = (mgi + 1) % 256; end
      3: mfc = d & 8'hBF;
      4: mfi = d & 8'h1F;
      5: if (mfi < 32) begin fm[mfi] = d; mfi++; end
      default: ;
    endcase
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    logic [7:0] e;
    bus_wr = 0; bus_rd = 1; bus_addr = a;
    case (a)
      0: e = mgc;
      1: e = 8'(mgi);
      2: begin e = gm[mgi]; mgi = (mgi + 1) % 256; end
      3: e = mfc;
      4: e = 8'(mfi);
      5: if (mfi < 32) begin e = fm[mfi]; mfi++; end else e = 8'h00;
      default: e = 8'h00;
    endcase
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    bus_wr = 0; bus_rd = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) gm[i] = 8'h00;
    for (int i = 0; i < 32; i++) fm[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 rd_valid after reset", {7'b0, rd_valid}, 8'h00);
    pix_idx = 8'h5A; #1;
    check("R1 gamma entry after reset", pix_gamma, 8'h00);
    rd(0, "R1 gamma cfg"); rd(1, "R1 gamma index"); rd(4, "R1 filter index"); rd(3, "R1 filter cfg");
    idle(2);

    wr(0, 8'hFF); wr(3, 8'hFF); rd(0, "R2 gamma cfg mask"); rd(3, "R2 filter cfg mask");
    wr(0, 8'h78); rd(0, "R2 gamma cfg mask 2"); wr(2, 8'h11); rd(0, "R2 gamma cfg unchanged");
    idle(1);

    wr(1, 8'hC3); rd(1, "R3 gamma index load");
    wr(1, 8'hFE);
    wr(2, 8'hA1); wr(2, 8'hB2); wr(2, 8'hC3); wr(2, 8'hD4);
    rd(1, "R4 gamma index wrapped");
    idle(1);
    pix_idx = 8'hFF; #1; check("R11 pixel entry 255", pix_gamma, 8'hB2);
    pix_idx = 8'h00; #1; check("R11 pixel entry 0", pix_gamma, 8'hC3);
    pix_idx = 8'hFE; #1; check("R9 first of burst", pix_gamma, 8'hA1);
    pix_idx = 8'h01; #1; check("R9 last of burst", pix_gamma, 8'hD4);
    rd(1, "R11 host index unmoved by pixel port");
    wr(1, 8'hFF);
    rd(2, "R5 gamma read 255"); rd(2, "R9 gamma read wraps to 0"); rd(2, "R5 gamma read 1");
    rd(1, "R5 gamma index after reads");
    idle(1);

    wr(4, 8'h3E); rd(4, "R6 filter index low bits");
    wr(5, 8'h5A); wr(5, 8'h6B); wr(5, 8'h7C);
    rd(4, "R8 filter index parked");
    wr(4, 8'h00); wr(5, 8'h01); wr(5, 8'h02); rd(4, "R7 filter index advanced");
    wr(4, 8'h1E);
    rd(5, "R7 filter read 30"); rd(5, "R7 filter read 31"); rd(5, "R8 filter read parked"); rd(5, "R8 filter read parked 2");
    rd(4, "R8 filter index stays 32");
    wr(4, 8'h00); rd(5, "R7 filter read 0"); rd(5, "R7 filter read 1");
    wr(4, 8'h1F); rd(5, "R8 dropped write left entry 31");
    idle(1);

    wr(6, 8'hEE); wr(7, 8'hDD); rd(6, "R12 unmapped read 6"); rd(7, "R12 unmapped read 7");
    rd(0, "R12 unmapped write left cfg");
    idle(1);
    bus_wr = 1; bus_rd = 1; bus_addr = 3'd1; bus_wdata = 8'h42; mgi = 8'h42;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    check("R12 no read strobe on write collision", {7'b0, rd_valid}, 8'h00);
    rd(1, "R12 collision write performed");
    idle(3);
    check("R10 all reads returned", 8'(exp_q.size()), 8'h00);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule